// File: doc/BRIEF.md
# Paced ADC Acquisition Controller

This block sits between a host's byte-wide register port and a 12-bit converter. It decides when the converter is asked for a conversion. The request can come from a host write, from an internal pacer tick, or from an external clock pulse. Completed results go into a 1024-word FIFO, and each word carries the 12-bit sample above a 4-bit channel tag. The block keeps data-ready and overrun flags and drives an interrupt request that can be enabled. The converter and the pacer timer are outside the block. They appear only as a conversion-done strobe with data and tag, and as a tick input.

A small sequencer controls paced acquisition. It has three states. SEQ_IDLE means pacing is off. SEQ_ARMWAIT means internal pacing is selected and an external start was requested, so the block waits for a rising edge on the trigger input. SEQ_RUN means pace events become conversion requests.

The transitions are:
- SEQ_IDLE to SEQ_RUN when pacing is switched on and no external start applies.
- SEQ_IDLE to SEQ_ARMWAIT when internal pacing is switched on with external start enabled.
- SEQ_ARMWAIT to SEQ_RUN on a trigger rising edge, or when the selection moves to external clocking.
- SEQ_ARMWAIT or SEQ_RUN to SEQ_IDLE whenever pacing is switched off.

The host programs the block and collects samples through six byte offsets. Reading offset 0 pops the FIFO.

Top module: `acq_ctrl`

## Requirements
- R1: A conversion-done strobe that is accepted pushes the word {sample[11:0], tag[3:0]} into a FIFO of 1024 words. A read (bus_rd) of offset 0 returns the oldest word and pops it. Reading an empty FIFO returns 0.
- R2: A write of any value to offset 0 raises conv_start for exactly one cycle, in the cycle after the write.
- R3: Offset 2 reads as a byte with bit 7 = data-ready, bit 5 = overrun and bit 0 = external-start enable. All other bits read 0. Only bit 0 is writable. Reset clears the whole byte.
- R4: A write of any value to offset 4 clears data-ready and overrun. If a conversion is accepted in the same cycle, data-ready ends up set.
- R5: Offset 5 is a control byte that reads back what was written. It holds pace select in bits [1:0], the line code in bits [6:4] and the interrupt enable in bit 7. irq_line always shows bits [6:4].
- R6: With pace select 3, a pacer_tick raises conv_start in the next cycle and ext_clk is ignored. With pace select 2, an ext_clk pulse does this and pacer_tick is ignored. With select 0 or 1, neither input causes a conversion.
- R7: If external-start enable is set when internal pacing (select 3) is switched on, ticks are ignored until ext_trig rises. Under select 2 the enable has no effect.
- R8: A conversion-done strobe is ignored unless a software conversion is pending or the sequencer is running. An ignored strobe changes neither the FIFO nor the flags.
- R9: A conversion accepted while the FIFO is full is dropped. It sets overrun, which stays set until offset 4 is written, and it does not set data-ready. Overrun alone never raises irq.
- R10: irq is high exactly when the interrupt enable is set and data-ready is set. Data-ready is set by every conversion that is accepted and stored.
- R11: Offset 3 reads din in bits [3:0] and zero above. A write to offset 3 loads dout from bits [3:0]. dout resets to 0.

Requirements R2, R6 and R7 are the ones whose conv_start behaviour the `assert_start_source_R6` property watches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops at offset 0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data, combinational on bus_addr |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | 12 | Converter sample |
| conv_chan | input | 4 | Channel tag of the sample |
| pacer_tick | input | 1 | Internal pacer pulse |
| ext_clk | input | 1 | External conversion pulse |
| ext_trig | input | 1 | External start trigger level |
| din | input | 4 | Digital inputs |
| dout | output | 4 | Digital outputs |
| conv_start | output | 1 | Conversion request to the converter |
| irq | output | 1 | Interrupt request |
| irq_line | output | 3 | Selected interrupt line code |

## Verification
Two events can land in the same cycle: an interrupt-clear write and the acceptance of a conversion result. The bench provokes this by driving the offset-4 write and conv_done on the same clock edge while paced acquisition runs. It then reads the status byte and irq, and expects data-ready to have survived. A second collision comes from overfilling the FIFO: after a clear, a dropped conversion must set overrun but not data-ready, and irq must stay low even though the interrupt enable is set.

// File: rtl/acq_pkg.sv
package acq_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_ARMWAIT = 2'd1,
        SEQ_RUN     = 2'd2
    } seq_state_t;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd2;
    localparam logic [2:0] OFS_DIO  = 3'd3;
    localparam logic [2:0] OFS_CLR  = 3'd4;
    localparam logic [2:0] OFS_CTRL = 3'd5;

    localparam logic [1:0] PACE_EXT = 2'd2;
    localparam logic [1:0] PACE_INT = 2'd3;
endpackage

// File: rtl/acq_fifo.sv
module acq_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [WIDTH-1:0]           wdata,
    output logic [WIDTH-1:0]           rdata,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int PW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr, rptr;
    logic             do_push, do_pop;

    assign full    = (count == (PW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == PW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (PW+1)'(DEPTH));

    assert_full_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> (count == $past(count)));
endmodule

// File: rtl/acq_seq.sv
module acq_seq
    import acq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pace_sel,
    input  logic       ext_start_en,
    input  logic       ext_trig,
    input  logic       pacer_tick,
    input  logic       ext_clk,
    output logic       running,
    output logic       pace_fire
);
    seq_state_t state_q, state_d;
    logic       trig_q;
    logic       pacing_on, trig_rise;

    assign pacing_on = (pace_sel == PACE_EXT) || (pace_sel == PACE_INT);
    assign trig_rise = ext_trig && !trig_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (pacing_on)
                    state_d = (ext_start_en && pace_sel == PACE_INT) ? SEQ_ARMWAIT : SEQ_RUN;
            end
            SEQ_ARMWAIT: begin
                if (!pacing_on)                              state_d = SEQ_IDLE;
                else if (trig_rise || pace_sel == PACE_EXT)  state_d = SEQ_RUN;
            end
            SEQ_RUN: begin
                if (!pacing_on) state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            trig_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            trig_q  <= ext_trig;
        end
    end

    always_comb begin
        running   = (state_q == SEQ_RUN);
        pace_fire = running &&
                    (((pace_sel == PACE_INT) && pacer_tick) ||
                     ((pace_sel == PACE_EXT) && ext_clk));
    end

    assert_wait_only_internal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_ARMWAIT) |-> ($past(pace_sel) == PACE_INT));
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
    import acq_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int TAG_W    = 4,
    parameter int DEPTH    = 1024,
    parameter int DIO_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [7:0]          bus_wdata,
    output logic [15:0]         bus_rdata,
    input  logic                conv_done,
    input  logic [SAMPLE_W-1:0] conv_data,
    input  logic [TAG_W-1:0]    conv_chan,
    input  logic                pacer_tick,
    input  logic                ext_clk,
    input  logic                ext_trig,
    input  logic [DIO_W-1:0]    din,
    output logic [DIO_W-1:0]    dout,
    output logic                conv_start,
    output logic                irq,
    output logic [2:0]          irq_line
);
    localparam int WORD_W = SAMPLE_W + TAG_W;
    localparam int CW     = $clog2(DEPTH) + 1;

    logic [7:0]        ctrl_q;
    logic              ext_en_q, dr_q, ovr_q, sw_pend_q;
    logic              wr_data, wr_stat, wr_dio, wr_clr, wr_ctrl, rd_pop;
    logic              running, pace_fire, accept;
    logic              fifo_full, fifo_empty;
    logic [WORD_W-1:0] fifo_head;
    logic [CW-1:0]     fifo_count;
    logic [7:0]        stat_byte;

    assign wr_data = bus_wr && (bus_addr == OFS_DATA);
    assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
    assign wr_dio  = bus_wr && (bus_addr == OFS_DIO);
    assign wr_clr  = bus_wr && (bus_addr == OFS_CLR);
    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign rd_pop  = bus_rd && (bus_addr == OFS_DATA);
    assign accept  = conv_done && (sw_pend_q || running);

    acq_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .pace_sel     (ctrl_q[1:0]),
        .ext_start_en (ext_en_q),
        .ext_trig     (ext_trig),
        .pacer_tick   (pacer_tick),
        .ext_clk      (ext_clk),
        .running      (running),
        .pace_fire    (pace_fire)
    );

    acq_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept),
        .pop   (rd_pop),
        .wdata ({conv_data, conv_chan}),
        .rdata (fifo_head),
        .full  (fifo_full),
        .empty (fifo_empty),
        .count (fifo_count)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            ext_en_q   <= 1'b0;
            dout       <= '0;
            dr_q       <= 1'b0;
            ovr_q      <= 1'b0;
            sw_pend_q  <= 1'b0;
            conv_start <= 1'b0;
        end else begin
            conv_start <= wr_data || pace_fire;
            if (wr_ctrl) ctrl_q   <= bus_wdata;
            if (wr_stat) ext_en_q <= bus_wdata[0];
            if (wr_dio)  dout     <= bus_wdata[DIO_W-1:0];
            if (wr_data)        sw_pend_q <= 1'b1;
            else if (conv_done) sw_pend_q <= 1'b0;
            if (accept && !fifo_full) dr_q <= 1'b1;
            else if (wr_clr)          dr_q <= 1'b0;
            if (accept && fifo_full)  ovr_q <= 1'b1;
            else if (wr_clr)          ovr_q <= 1'b0;
        end
    end

    assign stat_byte = {dr_q, 1'b0, ovr_q, 4'b0000, ext_en_q};
    assign irq       = ctrl_q[7] && dr_q;
    assign irq_line  = ctrl_q[6:4];

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DATA: bus_rdata = fifo_empty ? '0 : 16'(fifo_head);
            OFS_STAT: bus_rdata = {8'h00, stat_byte};
            OFS_DIO:  bus_rdata = 16'(din);
            OFS_CTRL: bus_rdata = {8'h00, ctrl_q};
            default:  bus_rdata = '0;
        endcase
    end

    assert_clear_effect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !accept) |=> (!dr_q && !ovr_q && !irq));

    assert_drop_sets_ovr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && fifo_full) |=> ovr_q);

    assert_ignored_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !sw_pend_q && !running && !rd_pop) |=> (fifo_count == $past(fifo_count)));

    assert_start_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ($past(wr_data) || $past(running)));
endmodule

// File: tb/acq_ctrl_tb.sv
module acq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic [3:0]  conv_chan = '0;
    logic        pacer_tick = 1'b0, ext_clk = 1'b0, ext_trig = 1'b0;
    logic [3:0]  din = '0;
    logic [3:0]  dout;
    logic        conv_start, irq;
    logic [2:0]  irq_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_done(conv_done),
        .conv_data(conv_data), .conv_chan(conv_chan), .pacer_tick(pacer_tick),
        .ext_clk(ext_clk), .ext_trig(ext_trig), .din(din), .dout(dout),
        .conv_start(conv_start), .irq(irq), .irq_line(irq_line)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input bit pop, output logic [15:0] v);
        bus_addr = a; #1;
        v = bus_rdata;
        if (pop) begin
            bus_rd = 1'b1;
            @(negedge clk);
            bus_rd = 1'b0;
        end
    endtask

    task automatic conv(input logic [11:0] d, input logic [3:0] c);
        conv_data = d; conv_chan = c; conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic tick(input bit internal);
        if (internal) pacer_tick = 1'b1; else ext_clk = 1'b1;
        @(negedge clk);
        pacer_tick = 1'b0; ext_clk = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(3'd2, 0, v); chk("R3 status reset", v, 0);
        rd(3'd5, 0, v); chk("R5 ctrl reset", v, 0);
        rd(3'd0, 0, v); chk("R1 empty read", v, 0);
        chk("R11 dout reset", dout, 0);
        chk("R10 irq reset", irq, 0);
    endtask

    task automatic t_dio_ctrl();
        logic [15:0] v;
        wr(3'd3, 8'hA5); chk("R11 dout write", dout, 5);
        din = 4'h9; rd(3'd3, 0, v); chk("R11 din read", v, 16'h0009);
        wr(3'd5, 8'h50); rd(3'd5, 0, v); chk("R5 ctrl readback", v, 8'h50);
        chk("R5 irq_line", irq_line, 5);
        wr(3'd2, 8'hFE); rd(3'd2, 0, v); chk("R3 only bit0 writable", v, 0);
    endtask

    task automatic t_sw_conv();
        logic [15:0] v;
        wr(3'd0, 8'h00); chk("R2 conv_start after write", conv_start, 1);
        @(negedge clk);  chk("R2 conv_start one cycle", conv_start, 0);
        conv(12'hABC, 4'h3);
        rd(3'd2, 0, v); chk("R10 data-ready set", v, 8'h80);
        chk("R10 irq masked", irq, 0);
        rd(3'd0, 1, v); chk("R1 word format", v, 16'hABC3);
        rd(3'd0, 0, v); chk("R1 popped to empty", v, 0);
        wr(3'd5, 8'h80); chk("R10 irq enabled", irq, 1);
        wr(3'd4, 8'h5A); chk("R4 clear drops irq", irq, 0);
        rd(3'd2, 0, v); chk("R4 status cleared", v, 0);
    endtask

    task automatic t_ignored();
        logic [15:0] v;
        conv(12'h123, 4'h1);
        rd(3'd2, 0, v); chk("R8 unrequested strobe no flag", v, 0);
        rd(3'd0, 0, v); chk("R8 unrequested strobe no push", v, 0);
        tick(1); chk("R6 tick ignored when pacer off", conv_start, 0);
        tick(0); chk("R6 ext_clk ignored when pacer off", conv_start, 0);
    endtask

    task automatic t_pacing();
        wr(3'd5, 8'h83); @(negedge clk);
        tick(1); chk("R6 internal tick fires", conv_start, 1);
        tick(0); chk("R6 ext_clk ignored under select 3", conv_start, 0);
        wr(3'd5, 8'h82); @(negedge clk);
        tick(0); chk("R6 ext_clk fires under select 2", conv_start, 1);
        tick(1); chk("R6 tick ignored under select 2", conv_start, 0);
        wr(3'd5, 8'h81); @(negedge clk);
        tick(1); chk("R6 select 1 is off", conv_start, 0);
        wr(3'd5, 8'h80); @(negedge clk);
    endtask

    task automatic t_ext_start();
        logic [15:0] v;
        wr(3'd2, 8'h01); rd(3'd2, 0, v); chk("R3 ext-start bit readback", v, 8'h01);
        wr(3'd5, 8'h83); @(negedge clk);
        tick(1); chk("R7 tick ignored before trigger", conv_start, 0);
        conv(12'h777, 4'h7);
        rd(3'd2, 0, v); chk("R8 strobe ignored while armed-wait", v, 8'h01);
        ext_trig = 1'b1; @(negedge clk); @(negedge clk);
        tick(1); chk("R7 tick fires after trigger", conv_start, 1);
        ext_trig = 1'b0;
        wr(3'd5, 8'h80); @(negedge clk);
        wr(3'd5, 8'h82); @(negedge clk);
        tick(0); chk("R7 enable ignored under select 2", conv_start, 1);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_collide();
        logic [15:0] v;
        bus_addr = 3'd4; bus_wr = 1'b1;
        conv_data = 12'h456; conv_chan = 4'h2; conv_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; conv_done = 1'b0;
        rd(3'd2, 0, v); chk("R4 completion wins over clear", v, 8'h80);
        chk("R10 irq after collision", irq, 1);
        rd(3'd0, 1, v); chk("R1 collided word stored", v, 16'h4562);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_overrun();
        logic [15:0] v;
        int bad = 0;
        for (int i = 0; i < 1024; i++) conv(12'(i), 4'(i));
        rd(3'd2, 0, v); chk("R9 full, no overrun yet", v, 8'h80);
        wr(3'd4, 8'h00);
        conv(12'hFFF, 4'hF);
        rd(3'd2, 0, v); chk("R9 drop sets overrun only", v, 8'h20);
        chk("R9 overrun alone no irq", irq, 0);
        conv(12'hEEE, 4'hE);
        rd(3'd2, 0, v); chk("R9 overrun sticky", v, 8'h20);
        for (int i = 0; i < 1024; i++) begin
            rd(3'd0, 1, v);
            if (v != {12'(i), 4'(i)}) bad++;
        end
        chk("R1 1024 words in order", bad, 0);
        rd(3'd0, 0, v); chk("R9 dropped word not stored", v, 0);
        wr(3'd4, 8'h00);
        rd(3'd2, 0, v); chk("R4 clear overrun", v, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dio_ctrl();
        t_sw_conv();
        t_ignored();
        t_pacing();
        t_ext_start();
        wr(3'd5, 8'h83); @(negedge clk);
        t_collide();
        t_overrun();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule